// File: doc/BRIEF.md
# EDO DRAM refresh and initialization engine

This block keeps an EDO DRAM array refreshed and brings it up after power-on. Once reset is released it waits out a startup pause of `PAUSE_US` microseconds with every strobe inactive. It then runs `INIT_REFRESHES` refresh cycles and raises `init_done`, which stays high until the next reset. From then on a pacer adds one pending refresh every `WINDOW_US * CLK_MHZ / REFRESH_ROWS` clock cycles. The defaults are a 64 ms window and 4096 rows; 8192 rows is the other common setting. The pacer holds at most `PEND_MAX` pending refreshes.

The engine does not own the strobe bus. It raises `req` towards the access sequencer and starts a refresh only on a clock edge where `grant` is also high. It drives the strobes while `bus_own` is high and pulses `ref_done` in the last cycle of each refresh. `urgent` tells the sequencer that the pending count is full and that an open hyper-page burst should be closed. The `ROW_MODE` parameter selects the refresh type. Mode 0 is CAS-before-RAS refresh. Mode 1 is RAS-only refresh, which presents a row from an internal counter on `row_addr`.

The controller is a Moore state machine with these states:
- `ST_PAUSE`: the startup wait.
- `ST_IDLE`: waiting for work and a grant.
- `ST_CAS_LEAD`: CAS low, RAS high.
- `ST_CAS_HOLD`: CAS and RAS both low.
- `ST_ROW_SETUP`: the row is on the bus, RAS high.
- `ST_RAS_LOW`: RAS low, CAS high.
- `ST_PRECHARGE`: RAS and CAS high.

The transitions are:
- pause-expired: `ST_PAUSE` to `ST_IDLE`.
- grant-taken: `ST_IDLE` to `ST_CAS_LEAD` in mode 0, or to `ST_ROW_SETUP` in mode 1.
- lead-elapsed: `ST_CAS_LEAD` to `ST_CAS_HOLD`.
- hold-elapsed: `ST_CAS_HOLD` to `ST_RAS_LOW`.
- setup-elapsed: `ST_ROW_SETUP` to `ST_RAS_LOW`.
- pulse-elapsed: `ST_RAS_LOW` to `ST_PRECHARGE`.
- precharge-elapsed: `ST_PRECHARGE` to `ST_IDLE`.

Each phase length is derived from a nanosecond parameter and `CLK_MHZ`. The conversion rounds up and never gives less than one cycle.

Top module: `edo_refresh_engine`

## Requirements
- R1: While reset is held, and for `PAUSE_US*CLK_MHZ` clock edges after its release, `ras_n`, `cas_n` and `we_n` are 1 and `req`, `bus_own`, `ref_done` and `init_done` are 0.
- R2: `init_done` rises at the edge that completes the `INIT_REFRESHES`-th refresh. It then stays 1 until reset. Refreshes done before that point never reduce the pending count.
- R3: In mode 0 a refresh drives `cas_n`=0 with `ras_n`=1 for CSR cycles. It then drives both low for CHR cycles and raises `cas_n` while `ras_n` is still 0. `we_n` is 1 in every cycle.
- R4: `ras_n` stays 0 for RAS cycles, then 1 for RP cycles before the engine can start again. RAS = max(ceil(TRAS_NS), CHR+1). RP = max(ceil(TRP_NS), ceil(TRC_NS)-RAS, ceil(TRPC_NS)). CSR, CHR and ASR are ceil of their ns values. Every ceil is taken of ns*CLK_MHZ/1000, with a minimum of 1.
- R5: In mode 1, `cas_n` stays 1 throughout. `row_addr` is presented for ASR cycles before `ras_n` falls and does not change while `ras_n` is 0.
- R6: In mode 1, `row_addr` advances by one at the edge that ends each refresh and wraps from `REFRESH_ROWS-1` to 0. In mode 0 it is constantly 0.
- R7: After `init_done`, one pending refresh is added every INTERVAL = floor(WINDOW_US*CLK_MHZ/REFRESH_ROWS) cycles. `req` is 1 exactly when the engine is idle and either initialization is unfinished or at least one refresh is pending.
- R8: The pending count saturates at `PEND_MAX`. `urgent` is 1 exactly when the count equals `PEND_MAX`. A tick and a completion on the same edge leave the count unchanged.
- R9: A refresh starts, and `bus_own` rises, only after an edge that saw both `req` and `grant` at 1. `grant` while `req` is 0 has no effect.
- R10: `ref_done` is 1 for exactly one cycle, which is the last precharge cycle of each refresh, with `ras_n`=`cas_n`=1 and `bus_own`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of `CLK_MHZ` MHz |
| rst_n | input | 1 | Asynchronous reset, active low |
| grant | input | 1 | The sequencer hands over the strobe bus |
| req | output | 1 | The engine wants the strobe bus |
| urgent | output | 1 | The pending count has reached `PEND_MAX` |
| ref_done | output | 1 | One-cycle pulse that ends a refresh |
| init_done | output | 1 | Startup pause and initialization refreshes are complete |
| bus_own | output | 1 | The engine is driving the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low, held high |
| row_addr | output | ROW_W = clog2(REFRESH_ROWS) | Refresh row for mode 1 |

## Verification
The properties assume only that `grant` is a level sampled at the rising edge. It may be high at any time, including while `req` is low, and it may be withheld for any length of time. The properties make no assumption about how long the sequencer holds `grant`. The stimulus changes `grant` on falling edges. It grants after a varying delay of zero to six cycles, inserts stray grant pulses while `req` is low, and withholds `grant` for several intervals so that the pending count saturates. Two instances are exercised side by side, one in mode 0 with the defaults and one in mode 1 with a short window and 16 rows, so that the row counter wraps several times.

// File: rtl/edo_rfsh_pkg.sv
package edo_rfsh_pkg;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_IDLE,
        ST_CAS_LEAD,
        ST_CAS_HOLD,
        ST_ROW_SETUP,
        ST_RAS_LOW,
        ST_PRECHARGE
    } rf_state_t;

    // Round a nanosecond figure up to whole clock cycles, never below one.
    function automatic int ns_to_cyc(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rfsh_startup.sv
module rfsh_startup #(
    parameter int PAUSE_CYC  = 20000,
    parameter int INIT_COUNT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fin,
    output logic pause_over,
    output logic init_need,
    output logic init_done
);
    localparam int PW = (PAUSE_CYC > 1) ? $clog2(PAUSE_CYC) : 1;
    localparam int IW = (INIT_COUNT > 1) ? $clog2(INIT_COUNT) : 1;

    logic [PW-1:0] pause_cnt;
    logic [IW-1:0] init_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pause_cnt <= PW'(PAUSE_CYC - 1);
        end else if (pause_cnt != '0) begin
            pause_cnt <= pause_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_cnt  <= '0;
            init_done <= 1'b0;
        end else if (fin && !init_done) begin
            init_cnt <= init_cnt + 1'b1;
            if (init_cnt == IW'(INIT_COUNT - 1)) begin
                init_done <= 1'b1;
            end
        end
    end

    assign pause_over = (pause_cnt == '0);
    assign init_need  = !init_done;

endmodule

// File: rtl/rfsh_pacer.sv
module rfsh_pacer #(
    parameter int INTERVAL_CYC = 1562,
    parameter int PEND_MAX     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic consume,
    output logic pending_any,
    output logic urgent
);
    localparam int VW = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;
    localparam int CW = $clog2(PEND_MAX + 1);

    logic [VW-1:0] ivl;
    logic [CW-1:0] pend;
    logic          tick;

    assign tick = run && (ivl == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ivl <= VW'(INTERVAL_CYC - 1);
        end else if (run) begin
            ivl <= tick ? VW'(INTERVAL_CYC - 1) : ivl - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            unique case ({tick, consume})
                2'b10: if (pend != CW'(PEND_MAX)) pend <= pend + 1'b1;
                2'b01: if (pend != '0) pend <= pend - 1'b1;
                default: pend <= pend;
            endcase
        end
    end

    assign pending_any = (pend != '0);
    assign urgent      = (pend == CW'(PEND_MAX));

endmodule

// File: rtl/rfsh_rowgen.sv
module rfsh_rowgen #(
    parameter int ROWS  = 4096,
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [ROW_W-1:0] row
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row <= '0;
        end else if (step) begin
            row <= (row == ROW_W'(ROWS - 1)) ? '0 : row + 1'b1;
        end
    end
endmodule

// File: rtl/edo_refresh_engine.sv
module edo_refresh_engine
    import edo_rfsh_pkg::*;
#(
    parameter int CLK_MHZ        = 100,
    parameter int PAUSE_US       = 200,
    parameter int INIT_REFRESHES = 8,
    parameter int REFRESH_ROWS   = 4096,
    parameter int WINDOW_US      = 64000,
    parameter int PEND_MAX       = 4,
    parameter bit ROW_MODE       = 1'b0,
    parameter int TRAS_NS        = 60,
    parameter int TRP_NS         = 40,
    parameter int TRC_NS         = 104,
    parameter int TCSR_NS        = 10,
    parameter int TCHR_NS        = 8,
    parameter int TASR_NS        = 0,
    parameter int TRPC_NS        = 5,
    localparam int ROW_W         = (REFRESH_ROWS > 1) ? $clog2(REFRESH_ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grant,
    output logic             req,
    output logic             urgent,
    output logic             ref_done,
    output logic             init_done,
    output logic             bus_own,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic [ROW_W-1:0] row_addr
);
    localparam int CSR_C    = ns_to_cyc(TCSR_NS, CLK_MHZ);
    localparam int CHR_C    = ns_to_cyc(TCHR_NS, CLK_MHZ);
    localparam int ASR_C    = ns_to_cyc(TASR_NS, CLK_MHZ);
    localparam int RAS_C    = imax(ns_to_cyc(TRAS_NS, CLK_MHZ), CHR_C + 1);
    localparam int RP_C     = imax(imax(ns_to_cyc(TRP_NS, CLK_MHZ),
                                        ns_to_cyc(TRC_NS, CLK_MHZ) - RAS_C),
                                   ns_to_cyc(TRPC_NS, CLK_MHZ));
    localparam int TMR_MAX  = imax(imax(imax(CSR_C, CHR_C), imax(ASR_C, RAS_C)), RP_C);
    localparam int TMR_W    = $clog2(TMR_MAX + 1);
    localparam int PAUSE_C  = PAUSE_US * CLK_MHZ;
    localparam int INTVL_C  = WINDOW_US * CLK_MHZ / REFRESH_ROWS;

    rf_state_t        st, st_nx;
    logic [TMR_W-1:0] tmr, tmr_nx;
    logic             pause_over, init_need, pending_any, need, consume;

    rfsh_startup #(
        .PAUSE_CYC (PAUSE_C),
        .INIT_COUNT(INIT_REFRESHES)
    ) u_startup (
        .clk       (clk),
        .rst_n     (rst_n),
        .fin       (ref_done),
        .pause_over(pause_over),
        .init_need (init_need),
        .init_done (init_done)
    );

    assign consume = ref_done && init_done;

    rfsh_pacer #(
        .INTERVAL_CYC(INTVL_C),
        .PEND_MAX    (PEND_MAX)
    ) u_pacer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (init_done),
        .consume    (consume),
        .pending_any(pending_any),
        .urgent     (urgent)
    );

    generate
        if (ROW_MODE) begin : g_row_only
            rfsh_rowgen #(
                .ROWS (REFRESH_ROWS),
                .ROW_W(ROW_W)
            ) u_rowgen (
                .clk  (clk),
                .rst_n(rst_n),
                .step (ref_done),
                .row  (row_addr)
            );
        end else begin : g_cbr
            assign row_addr = '0;
        end
    endgenerate

    assign need = init_need || pending_any;

    // Next state and phase timer.
    always_comb begin
        st_nx  = st;
        tmr_nx = (tmr == '0) ? '0 : tmr - 1'b1;
        unique case (st)
            ST_PAUSE: begin
                if (pause_over) st_nx = ST_IDLE;
            end
            ST_IDLE: begin
                if (need && grant) begin
                    if (ROW_MODE) begin
                        st_nx  = ST_ROW_SETUP;
                        tmr_nx = TMR_W'(ASR_C - 1);
                    end else begin
                        st_nx  = ST_CAS_LEAD;
                        tmr_nx = TMR_W'(CSR_C - 1);
                    end
                end
            end
            ST_CAS_LEAD: begin
                if (tmr == '0) begin
                    st_nx  = ST_CAS_HOLD;
                    tmr_nx = TMR_W'(CHR_C - 1);
                end
            end
            ST_CAS_HOLD: begin
                if (tmr == '0) begin
                    st_nx  = ST_RAS_LOW;
                    tmr_nx = TMR_W'(RAS_C - CHR_C - 1);
                end
            end
            ST_ROW_SETUP: begin
                if (tmr == '0) begin
                    st_nx  = ST_RAS_LOW;
                    tmr_nx = TMR_W'(RAS_C - 1);
                end
            end
            ST_RAS_LOW: begin
                if (tmr == '0) begin
                    st_nx  = ST_PRECHARGE;
                    tmr_nx = TMR_W'(RP_C - 1);
                end
            end
            ST_PRECHARGE: begin
                if (tmr == '0) st_nx = ST_IDLE;
            end
            default: st_nx = ST_PAUSE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_PAUSE;
            tmr <= '0;
        end else begin
            st  <= st_nx;
            tmr <= tmr_nx;
        end
    end

    // Moore outputs.
    always_comb begin
        req      = (st == ST_IDLE) && need;
        ref_done = (st == ST_PRECHARGE) && (tmr == '0);
        bus_own  = (st != ST_PAUSE) && (st != ST_IDLE);
        ras_n    = !((st == ST_CAS_HOLD) || (st == ST_RAS_LOW));
        cas_n    = !((st == ST_CAS_LEAD) || (st == ST_CAS_HOLD));
        we_n     = 1'b1;
    end

endmodule

// File: rtl/edo_refresh_checker.sv
module edo_refresh_checker #(
    parameter bit ROW_MODE = 1'b0,
    parameter int ROW_W    = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             grant,
    input logic             req,
    input logic             urgent,
    input logic             ref_done,
    input logic             init_done,
    input logic             bus_own,
    input logic             ras_n,
    input logic             cas_n,
    input logic [ROW_W-1:0] row_addr
);
    a_r2_init_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    a_r8_urgent_served: assert property (@(posedge clk) disable iff (!rst_n)
        urgent |-> (req || bus_own));

    a_r9_start_granted: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_own) |-> $past(req && grant));

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        ref_done |=> !ref_done);

    a_r10_done_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        ref_done |-> (ras_n && cas_n && bus_own));

    a_r6_row_moves_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(row_addr) |-> $past(ref_done));

    generate
        if (ROW_MODE) begin : g_row
            a_r5_cas_stays_high: assert property (@(posedge clk) disable iff (!rst_n)
                bus_own |-> cas_n);
            a_r5_row_held: assert property (@(posedge clk) disable iff (!rst_n)
                !ras_n |-> $stable(row_addr));
        end else begin : g_cbr
            a_r3_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(ras_n) |-> (!cas_n && $past(!cas_n)));
            a_r3_cas_rises_under_ras: assert property (@(posedge clk) disable iff (!rst_n)
                ($rose(cas_n) && bus_own) |-> !ras_n);
        end
    endgenerate
endmodule

bind edo_refresh_engine edo_refresh_checker #(
    .ROW_MODE(ROW_MODE),
    .ROW_W   (ROW_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .grant    (grant),
    .req      (req),
    .urgent   (urgent),
    .ref_done (ref_done),
    .init_done(init_done),
    .bus_own  (bus_own),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .row_addr (row_addr)
);

// File: tb/ref_track.sv
module ref_track #(
    parameter int CLK_MHZ   = 100,
    parameter int PAUSE_US  = 200,
    parameter int INIT      = 8,
    parameter int ROWS      = 4096,
    parameter int WINDOW_US = 64000,
    parameter int PMAX      = 4,
    parameter bit ROW_MODE  = 1'b0,
    parameter int TRAS_NS   = 60,
    parameter int TRP_NS    = 40,
    parameter int TRC_NS    = 104,
    parameter int TCSR_NS   = 10,
    parameter int TCHR_NS   = 8,
    parameter int TASR_NS   = 0,
    parameter int TRPC_NS   = 5,
    parameter int RW        = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold_off,
    input  logic          req,
    input  logic          urgent,
    input  logic          ref_done,
    input  logic          init_done,
    input  logic          bus_own,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic          we_n,
    input  logic [RW-1:0] row_addr,
    output logic          grant
);
    function automatic int up(input int ns);
        int c;
        c = (ns * CLK_MHZ + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int CSR   = up(TCSR_NS);
    localparam int CHR   = up(TCHR_NS);
    localparam int ASR   = up(TASR_NS);
    localparam int RASC  = (up(TRAS_NS) > CHR + 1) ? up(TRAS_NS) : CHR + 1;
    localparam int RPA   = (up(TRP_NS) > up(TRC_NS) - RASC) ? up(TRP_NS) : up(TRC_NS) - RASC;
    localparam int RPC   = (RPA > up(TRPC_NS)) ? RPA : up(TRPC_NS);
    localparam int PAUSE = PAUSE_US * CLK_MHZ;
    localparam int INTV  = WINDOW_US * CLK_MHZ / ROWS;

    // Entry bits: {done, own, ras_n, cas_n}
    logic [3:0] q[$];
    int  pause_left, init_cnt, pend, ivl, row;
    bit  initd;
    int  errs = 0, checks = 0, fin_cnt = 0;
    bit  urg_seen = 0, wrap_seen = 0;
    int  gdelay = 2, wcnt = 0, stray = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s (%m) actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            pause_left = PAUSE;
            q.delete();
            init_cnt = 0; pend = 0; ivl = INTV - 1; row = 0; initd = 0;
        end else begin
            bit fin, idle, need, tick, dec;
            fin  = (q.size() > 0) && q[0][3];
            idle = (pause_left == 0) && (q.size() == 0);
            need = (init_cnt < INIT) || (pend > 0);
            tick = initd && (ivl == 0);
            dec  = fin && initd;
            if (initd) ivl = (ivl == 0) ? INTV - 1 : ivl - 1;
            if (tick && !dec) pend = (pend < PMAX) ? pend + 1 : PMAX;
            else if (!tick && dec) pend = pend - 1;
            if (fin) begin
                fin_cnt++;
                if (!initd) begin
                    init_cnt++;
                    if (init_cnt == INIT) initd = 1;
                end
                if (ROW_MODE) begin
                    row = (row + 1) % ROWS;
                    if (row == 0) wrap_seen = 1;
                end
            end
            if (pause_left > 0) pause_left--;
            if (q.size() > 0) void'(q.pop_front());
            else if (idle && need && grant) begin
                if (ROW_MODE) begin
                    for (int i = 0; i < ASR; i++) q.push_back(4'b0111);
                    for (int i = 0; i < RASC; i++) q.push_back(4'b0101);
                end else begin
                    for (int i = 0; i < CSR; i++) q.push_back(4'b0110);
                    for (int i = 0; i < CHR; i++) q.push_back(4'b0100);
                    for (int i = 0; i < RASC - CHR; i++) q.push_back(4'b0101);
                end
                for (int i = 0; i < RPC - 1; i++) q.push_back(4'b0111);
                q.push_back(4'b1111);
            end
        end
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            grant = 1'b0;
            wcnt  = 0;
        end else begin
            logic [3:0] e;
            int exp_req;
            e = (q.size() > 0) ? q[0] : 4'b0011;
            exp_req = (pause_left == 0 && q.size() == 0 && (init_cnt < INIT || pend > 0)) ? 1 : 0;
            if (pause_left > 0) chk("R1 quiet pause", {req, bus_own, ref_done, init_done}, 0);
            chk("R4 ras_n", ras_n, e[1]);
            chk(ROW_MODE ? "R5 cas_n" : "R3 cas_n", cas_n, e[0]);
            chk("R9 bus_own", bus_own, e[2]);
            chk("R10 ref_done", ref_done, e[3]);
            chk("R3 we_n", we_n, 1);
            chk("R7 req", req, exp_req);
            chk("R8 urgent", urgent, (pend == PMAX) ? 1 : 0);
            chk("R2 init_done", init_done, initd);
            chk("R6 row_addr", row_addr, ROW_MODE ? row : 0);
            if (urgent) urg_seen = 1;
            stray++;
            if (req && !hold_off) begin
                if (wcnt >= gdelay) begin
                    grant  = 1'b1;
                    gdelay = (gdelay * 5 + 3) % 7;
                end else begin
                    grant = 1'b0;
                end
                wcnt++;
            end else begin
                wcnt  = 0;
                grant = (!req && (stray % 37 == 0)) ? 1'b1 : 1'b0;
            end
        end
    end
endmodule

// File: tb/sim_edo_refresh_engine.sv
module sim_edo_refresh_engine;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_off = 1'b0;
    always #5 clk = ~clk;

    localparam int INTV0 = 64000 * 100 / 4096;

    logic        g0, rq0, ug0, dn0, id0, ow0, ra0, ca0, we0;
    logic [11:0] row0;
    logic        g1, rq1, ug1, dn1, id1, ow1, ra1, ca1, we1;
    logic [3:0]  row1;

    int  errs = 0, checks = 0;
    bit  ended = 0;

    edo_refresh_engine u0 (
        .clk(clk), .rst_n(rst_n), .grant(g0), .req(rq0), .urgent(ug0),
        .ref_done(dn0), .init_done(id0), .bus_own(ow0), .ras_n(ra0),
        .cas_n(ca0), .we_n(we0), .row_addr(row0)
    );

    edo_refresh_engine #(
        .PAUSE_US(2), .REFRESH_ROWS(16), .WINDOW_US(64), .ROW_MODE(1'b1)
    ) u1 (
        .clk(clk), .rst_n(rst_n), .grant(g1), .req(rq1), .urgent(ug1),
        .ref_done(dn1), .init_done(id1), .bus_own(ow1), .ras_n(ra1),
        .cas_n(ca1), .we_n(we1), .row_addr(row1)
    );

    ref_track t0 (
        .clk(clk), .rst_n(rst_n), .hold_off(hold_off), .req(rq0), .urgent(ug0),
        .ref_done(dn0), .init_done(id0), .bus_own(ow0), .ras_n(ra0),
        .cas_n(ca0), .we_n(we0), .row_addr(row0), .grant(g0)
    );

    ref_track #(
        .PAUSE_US(2), .ROWS(16), .WINDOW_US(64), .ROW_MODE(1'b1)
    ) t1 (
        .clk(clk), .rst_n(rst_n), .hold_off(hold_off), .req(rq1), .urgent(ug1),
        .ref_done(dn1), .init_done(id1), .bus_own(ow1), .ras_n(ra1),
        .cas_n(ca1), .we_n(we1), .row_addr(row1), .grant(g1)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("Result: errors=%0d of %0d checks",
                     errs + t0.errs + t1.errs, checks + t0.checks + t1.checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state of both instances
        chk("R1 reset strobes u0", {ra0, ca0, we0}, 7);
        chk("R1 reset control u0", {rq0, ow0, dn0, id0}, 0);
        chk("R1 reset strobes u1", {ra1, ca1, we1}, 7);
        chk("R1 reset control u1", {rq1, ow1, dn1, id1}, 0);
        rst_n = 1'b1;
        while (!id0) @(posedge clk);
        repeat (3 * INTV0) @(posedge clk);
        hold_off = 1'b1;
        repeat (6 * INTV0) @(posedge clk);
        hold_off = 1'b0;
        repeat (4 * INTV0) @(posedge clk);
        @(negedge clk);
        chk("R2 init_done u0", id0, 1);
        chk("R2 init_done u1", id1, 1);
        chk("R8 saturation seen u0", t0.urg_seen, 1);
        chk("R8 saturation seen u1", t1.urg_seen, 1);
        chk("R6 row wrap seen u1", t1.wrap_seen, 1);
        chk("R6 enough refreshes u1", (t1.fin_cnt > 40) ? 1 : 0, 1);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL R2 watchdog actual=running expected=finished t=%0t", $time);
        finish_run();
    end
endmodule